// File: doc/BRIEF.md
# Byte-Addressed Memory with Selectable Byte Order

This block is a synchronous random-access store in which every byte has its own address. One request port serves 8-bit, 16-bit and 32-bit transfers. A mode input chooses the byte order. In little-endian order the least significant byte of a value sits at the lowest address of the access. In big-endian order the most significant byte sits there. Only whole bytes are reordered, never the hex digits inside a byte. A 16-bit transfer must start on an even address. A 32-bit transfer must start on an address that is a multiple of four. A request that breaks this rule, or that uses the unused size code, is refused: nothing is written, the read data stays zero and an error pulse is raised.

The byte capacity is `2**ADDR_W`. A 64 KB instance, with addresses 0 to 65,535, uses `ADDR_W = 16`. The default is smaller so that elaboration stays light. Storage is split into four byte-wide banks, selected by the two low address bits. Any aligned access therefore reaches all of its bytes in a single cycle. Read data is registered and appears one clock after the request.

Top module: `endian_byte_mem`

## Requirements
- R1: While `sel_n` is high, no byte is written or read, whatever `rw_n`, `size` or `addr` hold. In the next cycle `rdata` is zero and `err` is low.
- R2: With `sel_n` low, `rw_n` = 0 writes and `rw_n` = 1 reads. The read value is on `rdata` in the cycle after the request. After a write or an idle cycle `rdata` is zero.
- R3: Size code 00 is a byte access at any address. It writes `wdata[7:0]`, and a read returns the byte with bits 31:8 zero.
- R4: Size code 01 is a 16-bit access at an even address N. It covers bytes N and N+1, writes from `wdata[15:0]`, and a read returns bits 31:16 zero.
- R5: Size code 10 is a 32-bit access at an address that is a multiple of 4. It covers bytes N to N+3.
- R6: With `big_endian` = 0, value byte i (bits 8i+7:8i) is stored at address N+i. Writing 0x01020304 gives bytes 04,03,02,01 at N to N+3.
- R7: With `big_endian` = 1, the most significant byte is stored at address N. Writing 0x01020304 gives bytes 01,02,03,04. Nibbles inside a byte are never swapped.
- R8: A selected request that is misaligned, or that uses size code 11, changes no memory. In the next cycle it raises `err` for exactly one cycle and gives `rdata` = 0.
- R9: Bytes stored one at a time read back as wider values in either order. With 02,04,06,08 at 0x200 to 0x203, a 32-bit read gives 0x02040608 in big-endian order and 0x08060402 in little-endian order. A 16-bit read gives 0x0204 or 0x0402 and uses only 0x200 and 0x201.
- R10: While `rst_n` is low at a clock edge, `rdata` and `err` are zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Request select, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| addr | input | ADDR_W | Byte address |
| big_endian | input | 1 | Byte-order mode, 1 = big-endian |
| wdata | input | 32 | Write value, right-aligned |
| rdata | output | 32 | Read value, right-aligned and zero-extended |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest condition to observe is that a refused request leaves memory untouched. A misaligned write produces only an error pulse, so its effect has to be shown later at the read port. The stimulus therefore follows each refused write, and each deselected write, with an aligned 32-bit read of the same bytes, and compares the result with the earlier contents. Mixed-width cross-checks come next. Values are written as single bytes or halfwords in one byte order and read back with another width and the other order. This exposes any lane that is routed wrong in only one direction.

// File: rtl/emem_pkg.sv
// Package: shared size encoding and helpers for the byte-addressed memory.
// Assumes four byte lanes, which make up a 32-bit access.
package emem_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    // Last byte index inside an access of the given size.
    function automatic logic [1:0] last_idx(input size_e sz);
        case (sz)
            SZ_HALF: last_idx = 2'd1;
            SZ_WORD: last_idx = 2'd3;
            default: last_idx = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/access_check.sv
// access_check: decides whether a request is aligned to its size and
// which byte lanes it touches. Purely combinational.
// Assumes off is the two low address bits.
module access_check
    import emem_pkg::*;
(
    input  size_e      size,
    input  logic [1:0] off,
    output logic       misaligned,
    output logic [3:0] lane_mask
);

    // Alignment rule and lane footprint per size code.
    always_comb begin
        misaligned = 1'b0;
        lane_mask  = 4'b0000;
        case (size)
            SZ_BYTE: lane_mask = 4'b0001 << off;
            SZ_HALF: begin
                misaligned = off[0];
                lane_mask  = 4'b0011 << off;
            end
            SZ_WORD: begin
                misaligned = (off != 2'd0);
                lane_mask  = 4'b1111;
            end
            default: misaligned = 1'b1;
        endcase
        if (misaligned) lane_mask = 4'b0000;
    end

endmodule

// File: rtl/lane_router.sv
// lane_router: spreads a right-aligned write value across the byte lanes
// in the selected byte order. Lanes outside the access get zero.
// Assumes that the request is aligned.
module lane_router
    import emem_pkg::*;
(
    input  logic [DATA_W-1:0]     wdata,
    input  size_e                 size,
    input  logic [1:0]            off,
    input  logic                  big_endian,
    output logic [LANES-1:0][7:0] lane_wd
);

    logic [1:0] nm1;
    assign nm1 = last_idx(size);

    // For each lane, pick the value byte that belongs at that address.
    always_comb begin
        logic [1:0] k;
        logic [1:0] v;
        lane_wd = '0;
        for (int l = 0; l < LANES; l++) begin
            k = 2'(l) - off;
            v = big_endian ? (nm1 - k) : k;
            if (k <= nm1) lane_wd[l] = wdata[8*v +: 8];
        end
    end

endmodule

// File: rtl/read_assembler.sv
// read_assembler: builds the right-aligned read value from the registered
// lane bytes and the registered request fields. The output is zero when no
// read completed in the previous cycle.
module read_assembler
    import emem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_valid,
    input  size_e                 size,
    input  logic [1:0]            off,
    input  logic                  big_endian,
    input  logic [LANES-1:0][7:0] lane_rd,
    output logic [DATA_W-1:0]     rdata
);

    logic [1:0] nm1;
    assign nm1 = last_idx(size);

    // For each value byte, fetch it from the lane that holds its address.
    always_comb begin
        logic [1:0] k;
        logic [1:0] lane;
        rdata = '0;
        for (int v = 0; v < LANES; v++) begin
            k    = big_endian ? (nm1 - 2'(v)) : 2'(v);
            lane = off + k;
            if (rd_valid && (2'(v) <= nm1)) rdata[8*v +: 8] = lane_rd[lane];
        end
    end

    // R3
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && size == SZ_BYTE) |-> (rdata[31:8] == 24'h0));

    // R4
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && size == SZ_HALF) |-> (rdata[31:16] == 16'h0));

endmodule

// File: rtl/byte_bank.sv
// byte_bank: one byte-wide single-port store with a registered read.
// Assumes write and read are never requested in the same cycle.
module byte_bank #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wd,
    output logic [7:0]       rd
);

    localparam int ROWS = 1 << ROW_W;

    logic [7:0] mem [ROWS];

    // Store a byte, or capture the addressed byte for the next cycle.
    always_ff @(posedge clk) begin
        if (we) mem[row] <= wd;
        if (re) rd <= mem[row];
    end

endmodule

// File: rtl/endian_byte_mem.sv
// endian_byte_mem: byte-addressed store of 2**ADDR_W bytes that serves
// 8/16/32-bit accesses with selectable byte order. Storage is four byte
// banks indexed by addr[1:0]. Reads return one cycle after the request.
// Refused requests (misaligned, or size 11) pulse err and change nothing.
module endian_byte_mem
    import emem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rw_n,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              big_endian,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);

    localparam int ROW_W = ADDR_W - 2;

    size_e                 sz;
    logic [1:0]            off;
    logic [ROW_W-1:0]      row;
    logic                  mis;
    logic [3:0]            mask;
    logic                  wr_go;
    logic                  rd_go;
    logic [LANES-1:0][7:0] lane_wd;
    logic [LANES-1:0][7:0] lane_rd;

    logic                  rd_v_q;
    logic                  err_q;
    size_e                 sz_q;
    logic [1:0]            off_q;
    logic                  be_q;

    assign sz  = size_e'(size);
    assign off = addr[1:0];
    assign row = addr[ADDR_W-1:2];

    access_check u_check (
        .size       (sz),
        .off        (off),
        .misaligned (mis),
        .lane_mask  (mask)
    );

    // Accepted write and read strobes.
    assign wr_go = !sel_n && !rw_n && !mis;
    assign rd_go = !sel_n &&  rw_n && !mis;

    lane_router u_router (
        .wdata      (wdata),
        .size       (sz),
        .off        (off),
        .big_endian (big_endian),
        .lane_wd    (lane_wd)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        byte_bank #(.ROW_W(ROW_W)) u_bank (
            .clk (clk),
            .we  (wr_go && mask[l]),
            .re  (rd_go),
            .row (row),
            .wd  (lane_wd[l]),
            .rd  (lane_rd[l])
        );
    end

    // Request pipeline: remember what the registered read must be assembled with.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q <= 1'b0;
            err_q  <= 1'b0;
            sz_q   <= SZ_BYTE;
            off_q  <= 2'd0;
            be_q   <= 1'b0;
        end else begin
            rd_v_q <= rd_go;
            err_q  <= !sel_n && mis;
            sz_q   <= sz;
            off_q  <= off;
            be_q   <= big_endian;
        end
    end

    read_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_v_q),
        .size       (sz_q),
        .off        (off_q),
        .big_endian (be_q),
        .lane_rd    (lane_rd),
        .rdata      (rdata)
    );

    assign err = err_q;

    // R8
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == 32'h0));

    // R8
    err_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(sel_n));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_n) |-> (rdata == 32'h0 && !err));

    // R2
    write_no_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !rw_n) |=> (rdata == 32'h0));

endmodule

// File: tb/tb_endian_byte_mem.sv
// Bench: table-driven walk of accesses, then directed reset checks.
module tb_endian_byte_mem;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n;
    logic        rw_n;
    logic [1:0]  size;
    logic [11:0] addr;
    logic        big_endian;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    endian_byte_mem #(.ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw_n(rw_n), .size(size),
        .addr(addr), .big_endian(big_endian), .wdata(wdata),
        .rdata(rdata), .err(err)
    );

    typedef struct packed {
        logic        s_n;
        logic        r_n;
        logic [1:0]  sz;
        logic [11:0] a;
        logic        be;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'd2,12'h100,1'b1,32'h01020304,32'h0,1'b0,4'd7},        // R7 word write BE
        '{1'b0,1'b1,2'd0,12'h100,1'b1,32'h0,32'h00000001,1'b0,4'd7},        // R7 byte 0x100
        '{1'b0,1'b1,2'd0,12'h103,1'b1,32'h0,32'h00000004,1'b0,4'd3},        // R3 byte 0x103
        '{1'b0,1'b1,2'd2,12'h100,1'b0,32'h0,32'h04030201,1'b0,4'd6},        // R6 LE view
        '{1'b0,1'b0,2'd2,12'h104,1'b0,32'h01020304,32'h0,1'b0,4'd6},        // R6 word write LE
        '{1'b0,1'b1,2'd0,12'h104,1'b0,32'h0,32'h00000004,1'b0,4'd6},        // R6 low address
        '{1'b0,1'b1,2'd0,12'h107,1'b0,32'h0,32'h00000001,1'b0,4'd6},        // R6 high address
        '{1'b0,1'b0,2'd0,12'h200,1'b0,32'hAABBCC02,32'h0,1'b0,4'd3},        // R3 byte writes
        '{1'b0,1'b0,2'd0,12'h201,1'b1,32'hAABBCC04,32'h0,1'b0,4'd3},
        '{1'b0,1'b0,2'd0,12'h202,1'b0,32'hAABBCC06,32'h0,1'b0,4'd3},
        '{1'b0,1'b0,2'd0,12'h203,1'b1,32'hAABBCC08,32'h0,1'b0,4'd3},
        '{1'b0,1'b1,2'd2,12'h200,1'b1,32'h0,32'h02040608,1'b0,4'd9},        // R9 word BE
        '{1'b0,1'b1,2'd2,12'h200,1'b0,32'h0,32'h08060402,1'b0,4'd9},        // R9 word LE
        '{1'b0,1'b1,2'd1,12'h200,1'b1,32'h0,32'h00000204,1'b0,4'd9},        // R9 half BE
        '{1'b0,1'b1,2'd1,12'h200,1'b0,32'h0,32'h00000402,1'b0,4'd9},        // R9 half LE
        '{1'b0,1'b1,2'd1,12'h202,1'b1,32'h0,32'h00000608,1'b0,4'd4},        // R4 upper half
        '{1'b0,1'b0,2'd1,12'h201,1'b1,32'h0000FFFF,32'h0,1'b1,4'd8},        // R8 odd half write
        '{1'b0,1'b1,2'd2,12'h200,1'b1,32'h0,32'h02040608,1'b0,4'd8},        // R8 unchanged
        '{1'b0,1'b0,2'd2,12'h202,1'b0,32'hFFFFFFFF,32'h0,1'b1,4'd5},        // R5 misaligned word
        '{1'b0,1'b1,2'd3,12'h200,1'b1,32'h0,32'h0,1'b1,4'd8},               // R8 size 11
        '{1'b1,1'b0,2'd2,12'h200,1'b1,32'hDEADBEEF,32'h0,1'b0,4'd1},        // R1 deselected write
        '{1'b0,1'b1,2'd2,12'h200,1'b1,32'h0,32'h02040608,1'b0,4'd1},        // R1 unchanged
        '{1'b1,1'b1,2'd3,12'h201,1'b1,32'h0,32'h0,1'b0,4'd1},               // R1 no error
        '{1'b0,1'b0,2'd1,12'h300,1'b0,32'hFFFF1234,32'h0,1'b0,4'd4},        // R4 half write LE
        '{1'b0,1'b1,2'd0,12'h300,1'b0,32'h0,32'h00000034,1'b0,4'd4},
        '{1'b0,1'b1,2'd0,12'h301,1'b0,32'h0,32'h00000012,1'b0,4'd4},
        '{1'b0,1'b1,2'd1,12'h300,1'b1,32'h0,32'h00003412,1'b0,4'd7},        // R7 half BE
        '{1'b0,1'b0,2'd1,12'h302,1'b1,32'h0000A1B2,32'h0,1'b0,4'd7},        // R7 half write BE
        '{1'b0,1'b1,2'd2,12'h300,1'b0,32'h0,32'hB2A11234,1'b0,4'd2}         // R2 mixed read
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #500us;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; rw_n = 1'b1; size = 2'd0;
        addr = '0; big_endian = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 rdata", rdata, 32'h0);
        chk("R10 err", {31'h0, err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            sel_n = VECS[i].s_n; rw_n = VECS[i].r_n; size = VECS[i].sz;
            addr = VECS[i].a; big_endian = VECS[i].be; wdata = VECS[i].wd;
            @(negedge clk);
            chk($sformatf("R%0d rdata v%0d", VECS[i].rq, i), rdata, VECS[i].exp_rd);
            chk($sformatf("R%0d err v%0d", VECS[i].rq, i), {31'h0, err}, {31'h0, VECS[i].exp_err});
        end

        // R8: error pulse lasts one cycle when followed by an idle cycle
        sel_n = 1'b0; rw_n = 1'b1; size = 2'd2; addr = 12'h101;
        @(negedge clk);
        sel_n = 1'b1;
        chk("R8 err pulse", {31'h0, err}, 32'h1);
        @(negedge clk);
        chk("R8 err cleared", {31'h0, err}, 32'h0);

        // R10: a read issued with reset low returns nothing
        sel_n = 1'b0; rw_n = 1'b1; size = 2'd2; addr = 12'h200; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 rdata in reset", rdata, 32'h0);
        chk("R10 err in reset", {31'h0, err}, 32'h0);
        rst_n = 1'b1; big_endian = 1'b1;
        @(negedge clk);
        chk("R2 read after reset", rdata, 32'h02040608);
        sel_n = 1'b1;
        @(negedge clk);
        chk("R2 idle zero", rdata, 32'h0);

        finish_run();
    end

endmodule